// File: doc/BRIEF.md
# Iterative Non-Restoring Integer Divider

The block divides a double-width dividend by a single-width divisor and returns a single-width quotient. With the default width of 32, the dividend is 64 bits and arrives as a high word and a low word, and the divisor is 32 bits. A start strobe samples the operands and a mode bit that selects signed or unsigned division for that operation alone. The block then runs a radix-2 non-restoring iteration that retires one quotient digit per clock. A one-cycle done strobe presents the quotient together with an overflow flag and a divide-by-zero flag. No remainder is produced.

Every operation takes the same number of cycles, whatever the operand values: one setup cycle that forms operand magnitudes and pre-checks the range, W digit cycles, one cycle that converts the signed-digit quotient to binary, one cycle that applies the sign and saturation, and one output cycle. The result registers keep their values until the next done strobe. A start strobe that arrives while an operation is running is dropped.

Top module: `nrdiv_core`

## Requirements
- R1: In unsigned mode (mode bit 0) with a nonzero divisor D and dividend N = {high word, low word} where high word < D, the quotient equals floor(N / D), the overflow flag is 0 and the divide-by-zero flag is 0.
- R2: In signed mode (mode bit 1), both operands are two's complement. The quotient is |N| / |D| truncated toward zero and negated when the operand signs differ. When that value lies in [-2^31, 2^31-1] it is returned with both flags 0.
- R3: The done strobe is high for exactly one cycle, during the 36th cycle after the clock edge that accepted start (W+4 edges later), and it is low in the cycle before and the cycle after.
- R4: In unsigned mode with D nonzero and high word >= D, the overflow flag is 1 and the quotient is all ones.
- R5: In signed mode, when the true quotient falls outside [-2^31, 2^31-1], the overflow flag is 1 and the quotient saturates to 0x7FFFFFFF for a positive result or to 0x80000000 for a negative result.
- R6: A zero divisor in either mode gives divide-by-zero flag 1 and overflow flag 0 at done. The quotient value is then unspecified.
- R7: A start strobe while an operation is in progress is ignored. The running result, its timing, and the number of done strobes are unchanged.
- R8: While reset is asserted, done, quotient and both flags read 0.
- R9: Quotient and flags hold their values between done strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start strobe; operands and mode are sampled when the block is idle |
| signed_i | input | 1 | 1 = signed division, 0 = unsigned |
| dvd_hi_i | input | 32 | Upper word of the dividend |
| dvd_lo_i | input | 32 | Lower word of the dividend |
| dvs_i | input | 32 | Divisor |
| done_o | output | 1 | One-cycle result strobe |
| quot_o | output | 32 | Quotient |
| ovf_o | output | 1 | Quotient did not fit; quotient is saturated |
| dz_o | output | 1 | Divisor was zero |

## Verification
Each result is due in the cycle after the 36th rising edge that follows the edge at which start is accepted. The bench counts exactly that many edges after driving start and samples at the falling edge. It checks that done is low one cycle earlier, high in that cycle, and low one cycle later, and it reads the quotient and flags only in the done cycle. For the ignored-start test, the bench keeps watching past the cycle where a wrongly accepted second start would have produced its result, and it confirms there that no extra strobe appears and the quotient is unchanged.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SETUP = 3'd1,
    S_ITER  = 3'd2,
    S_CORR  = 3'd3,
    S_FIX   = 3'd4,
    S_OUT   = 3'd5
  } nrdiv_st_e;
endpackage

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      start_i,
  output nrdiv_st_e state_o,
  output logic      accept_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  nrdiv_st_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;

  assign accept_o = start_i && (state_q == S_IDLE);
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      S_IDLE:  if (start_i) state_d = S_SETUP;
      S_SETUP: begin
        state_d = S_ITER;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      S_ITER: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) state_d = S_CORR;
      end
      S_CORR:  state_d = S_FIX;
      S_FIX:   state_d = S_OUT;
      S_OUT:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // R7: setup is entered only from idle, so a start while busy starts nothing
  assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> (state_q != S_SETUP));

  // R3: the digit phase never runs past W cycles
  assert_iter_bound_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_ITER && cnt_q == CW'(W - 1)) |=> (state_q == S_CORR));
endmodule

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
  parameter int W = 32
) (
  input  logic [W+1:0] rem_i,
  input  logic         bit_i,
  input  logic [W-1:0] dvs_i,
  output logic [W+1:0] rem_o,
  output logic         digit_o
);
  logic [W+1:0] shifted;
  logic [W+1:0] dext;

  assign shifted = {rem_i[W:0], bit_i};
  assign dext    = {2'b00, dvs_i};
  // digit +1 when the partial remainder is non-negative: subtract, else add
  assign digit_o = ~rem_i[W+1];
  assign rem_o   = digit_o ? (shifted - dext) : (shifted + dext);
endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
  parameter int W = 32
) (
  input  logic         sgn_i,
  input  logic         negq_i,
  input  logic         ovf_pre_i,
  input  logic         dz_i,
  input  logic [W-1:0] qmag_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  logic         range_bad;
  logic [W-1:0] sat;

  always_comb begin
    if (!sgn_i)      range_bad = 1'b0;
    else if (negq_i) range_bad = (qmag_i > SMIN);
    else             range_bad = qmag_i[W-1];
    sat   = sgn_i ? (negq_i ? SMIN : SMAX) : '1;
    ovf_o = !dz_i && (ovf_pre_i || range_bad);
    if (dz_i)        res_o = '0;
    else if (ovf_o)  res_o = sat;
    else if (negq_i) res_o = -qmag_i;
    else             res_o = qmag_i;
  end
endmodule

// File: rtl/nrdiv_core.sv
module nrdiv_core
  import nrdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dvd_hi_i,
  input  logic [W-1:0] dvd_lo_i,
  input  logic [W-1:0] dvs_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic         ovf_o,
  output logic         dz_o
);
  localparam int RW  = W + 2;
  localparam int LAT = W + 4;
  localparam int LCW = $clog2(LAT + 2);
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  nrdiv_st_e state;
  logic      accept;

  nrdiv_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .state_o  (state),
    .accept_o (accept)
  );

  logic [RW-1:0] rem_q, rem_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [W-1:0]  dm_q, dm_d;
  logic          sgn_q, sgn_d, negq_q, negq_d, dz_q, dz_d, ovfp_q, ovfp_d;
  logic [W-1:0]  quot_d;
  logic          ovf_od, dz_od, done_d, out_en;

  // setup: magnitudes of the raw operands held in rem/acc/dm
  logic [2*W-1:0] raw, mag;
  logic [W-1:0]   dmag;
  logic           nneg, dneg;
  assign raw  = {rem_q[W-1:0], acc_q};
  assign nneg = sgn_q & raw[2*W-1];
  assign dneg = sgn_q & dm_q[W-1];
  assign mag  = nneg ? -raw : raw;
  assign dmag = dneg ? -dm_q : dm_q;

  logic [RW-1:0] step_rem;
  logic          step_dig;
  nrdiv_step #(.W(W)) u_step (
    .rem_i   (rem_q),
    .bit_i   (acc_q[W-1]),
    .dvs_i   (dm_q),
    .rem_o   (step_rem),
    .digit_o (step_dig)
  );

  logic [W-1:0] fix_res;
  logic         fix_ovf;
  nrdiv_fix #(.W(W)) u_fix (
    .sgn_i     (sgn_q),
    .negq_i    (negq_q),
    .ovf_pre_i (ovfp_q),
    .dz_i      (dz_q),
    .qmag_i    (acc_q),
    .res_o     (fix_res),
    .ovf_o     (fix_ovf)
  );

  always_comb begin
    rem_d  = rem_q;
    acc_d  = acc_q;
    dm_d   = dm_q;
    sgn_d  = sgn_q;
    negq_d = negq_q;
    dz_d   = dz_q;
    ovfp_d = ovfp_q;
    quot_d = quot_o;
    ovf_od = ovf_o;
    dz_od  = dz_o;
    done_d = 1'b0;
    out_en = 1'b0;
    case (state)
      S_IDLE: if (accept) begin
        rem_d = {2'b00, dvd_hi_i};
        acc_d = dvd_lo_i;
        dm_d  = dvs_i;
        sgn_d = signed_i;
      end
      S_SETUP: begin
        rem_d  = {2'b00, mag[2*W-1:W]};
        acc_d  = mag[W-1:0];
        dm_d   = dmag;
        negq_d = nneg ^ dneg;
        dz_d   = (dmag == '0);
        ovfp_d = (dmag != '0) && (mag[2*W-1:W] >= dmag);
      end
      S_ITER: begin
        rem_d = step_rem;
        acc_d = {acc_q[W-2:0], step_dig};
      end
      // signed-digit to binary: Q = 2P + 1, minus 1 when remainder ends negative
      S_CORR: acc_d = {acc_q[W-2:0], ~rem_q[RW-1]};
      S_FIX: begin
        acc_d  = fix_res;
        ovfp_d = fix_ovf;
      end
      S_OUT: begin
        out_en = 1'b1;
        quot_d = acc_q;
        ovf_od = ovfp_q;
        dz_od  = dz_q;
        done_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      acc_q  <= '0;
      dm_q   <= '0;
      sgn_q  <= 1'b0;
      negq_q <= 1'b0;
      dz_q   <= 1'b0;
      ovfp_q <= 1'b0;
      quot_o <= '0;
      ovf_o  <= 1'b0;
      dz_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      acc_q  <= acc_d;
      dm_q   <= dm_d;
      sgn_q  <= sgn_d;
      negq_q <= negq_d;
      dz_q   <= dz_d;
      ovfp_q <= ovfp_d;
      done_o <= done_d;
      if (out_en) begin
        quot_o <= quot_d;
        ovf_o  <= ovf_od;
        dz_o   <= dz_od;
      end
    end
  end

  // latency watch counter for the timing check
  logic [LCW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                    lat_q <= '0;
    else if (accept)                lat_q <= LCW'(1);
    else if (lat_q != '0 && !done_o) lat_q <= lat_q + 1'b1;
    else                            lat_q <= '0;
  end

  // R3: done arrives exactly LAT edges after the accepting edge
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> (lat_q == LCW'(LAT + 1)));

  // R3: done is a single-cycle strobe
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4: unsigned overflow saturates to all ones
  assert_sat_unsigned_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_o && ovf_o && !sgn_q) |-> (quot_o == '1));

  // R5: signed overflow saturates to one of the extremes
  assert_sat_signed_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_o && ovf_o && sgn_q) |-> (quot_o == (negq_q ? SMIN : SMAX)));

  // R6: zero divisor never reports overflow
  assert_dz_no_ovf_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_o && dz_o) |-> !ovf_o);

  // R9: results only change together with a done strobe
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !done_o |-> ($stable(quot_o) && $stable(ovf_o) && $stable(dz_o)));
endmodule

// File: tb/sim_nrdiv_core.sv
module sim_nrdiv_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, signed_i;
  logic [31:0] dvd_hi_i, dvd_lo_i, dvs_i;
  logic        done_o, ovf_o, dz_o;
  logic [31:0] quot_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  nrdiv_core u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i), .dvs_i(dvs_i),
    .done_o(done_o), .quot_o(quot_o), .ovf_o(ovf_o), .dz_o(dz_o)
  );

  // {mode, hi, lo, divisor, quotient, ovf, dz}
  localparam int NV = 18;
  localparam logic [130:0] VEC [NV] = '{
    {1'b0, 32'h00000000, 32'h00000064, 32'h00000007, 32'h0000000E, 1'b0, 1'b0},
    {1'b0, 32'h00000001, 32'h00000000, 32'h00000002, 32'h80000000, 1'b0, 1'b0},
    {1'b0, 32'h00000001, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b1, 1'b0},
    {1'b0, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0},
    {1'b0, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0},
    {1'b0, 32'h00000005, 32'h00000005, 32'h00000000, 32'h00000000, 1'b0, 1'b1},
    {1'b1, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'h00000007, 32'hFFFFFFF2, 1'b0, 1'b0},
    {1'b1, 32'h00000000, 32'h00000064, 32'hFFFFFFF9, 32'hFFFFFFF2, 1'b0, 1'b0},
    {1'b1, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'hFFFFFFF9, 32'h0000000E, 1'b0, 1'b0},
    {1'b1, 32'h00000000, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b0},
    {1'b1, 32'hFFFFFFFF, 32'h80000000, 32'h00000001, 32'h80000000, 1'b0, 1'b0},
    {1'b1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 1'b0},
    {1'b1, 32'h00000000, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b0},
    {1'b1, 32'h00000001, 32'h00000000, 32'hFFFFFFFE, 32'h80000000, 1'b0, 1'b0},
    {1'b1, 32'h00000000, 32'h00000009, 32'h00000000, 32'h00000000, 1'b0, 1'b1},
    {1'b0, 32'h00000000, 32'h00000007, 32'h00000009, 32'h00000000, 1'b0, 1'b0},
    {1'b1, 32'hFFFFFFFF, 32'hFFFFFFF9, 32'h00000009, 32'h00000000, 1'b0, 1'b0},
    {1'b1, 32'h00000100, 32'h00000000, 32'h00000002, 32'h7FFFFFFF, 1'b1, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // drives one start at a negedge; returns after the accepting edge, at negedge
  task automatic launch(input logic m, input logic [31:0] hi, input logic [31:0] lo,
                        input logic [31:0] d);
    start_i = 1'b1; signed_i = m; dvd_hi_i = hi; dvd_lo_i = lo; dvs_i = d;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    start_i = 1'b0; signed_i = 1'b0;
    dvd_hi_i = '0; dvd_lo_i = '0; dvs_i = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(done_o == 1'b0, "R8 done in reset", {63'd0, done_o}, 64'd0);
    chk(quot_o == 32'd0, "R8 quotient in reset", {32'd0, quot_o}, 64'd0);
    chk({ovf_o, dz_o} == 2'b00, "R8 flags in reset", {62'd0, ovf_o, dz_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [130:0] v;
      string tag;
      v = VEC[i];
      tag = v[0] ? "R6" : (v[1] ? (v[130] ? "R5" : "R4") : (v[130] ? "R2" : "R1"));
      launch(v[130], v[129:98], v[97:66], v[65:34]);
      repeat (35) @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0, "R3 done early", {63'd0, done_o}, 64'd0);
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b1, "R3 done at cycle 36", {63'd0, done_o}, 64'd1);
      if (!v[0])
        chk(quot_o == v[33:2], tag, {32'd0, quot_o}, {32'd0, v[33:2]});
      chk({ovf_o, dz_o} == v[1:0], tag, {62'd0, ovf_o, dz_o}, {62'd0, v[1:0]});
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0, "R3 done single cycle", {63'd0, done_o}, 64'd0);
    end

    // R7: start while busy is ignored; R9: results hold afterwards
    launch(1'b0, 32'd0, 32'd100, 32'd7);
    repeat (5) @(posedge clk);
    @(negedge clk);
    launch(1'b0, 32'd0, 32'd1000, 32'd10);
    repeat (29) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 no early done", {63'd0, done_o}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b1, "R7 first result on time", {63'd0, done_o}, 64'd1);
    chk(quot_o == 32'd14, "R7 first operands kept", {32'd0, quot_o}, 64'd14);
    for (int k = 0; k < 12; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0, "R7 no extra done", {63'd0, done_o}, 64'd0);
      chk(quot_o == 32'd14, "R9 quotient held", {32'd0, quot_o}, 64'd14);
    end

    // R8: reset in the middle of an operation clears outputs
    launch(1'b1, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'h7);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(quot_o == 32'd0, "R8 quotient cleared by reset", {32'd0, quot_o}, 64'd0);
    chk(done_o == 1'b0, "R8 done cleared by reset", {63'd0, done_o}, 64'd0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(done_o == 1'b0 && quot_o == 32'd0, "R8 aborted operation gives no result",
        {31'd0, done_o, quot_o}, 64'd0);

    summary();
    $finish;
  end
endmodule